// File: doc/BRIEF.md
# Dual Address Cycle Decoder for a 32-bit Parallel Bus Target

This block watches the address phase of a 32-bit multiplexed address/data bus on the target side. It registers the frame signal (active low), the address/data lines and the command/byte-enable lines (active low) on every rising clock edge. It finds the clock on which a new transaction begins and decides whether the transaction uses one address clock or two.

A single-address transaction gives a command and a 32-bit address on one clock. A dual-address transaction puts a reserved code on the command lines in its first clock, together with the low 32 address bits. In the second clock it carries the upper address bits, right-justified, and the real command. The decoder assembles a 44-bit address and a 4-bit command and reports them with a one-cycle valid strobe and a dual flag. A malformed dual-address transaction produces a one-cycle error pulse and no valid strobe.

Data phases, ready handshaking, device select, parity and arbitration are handled elsewhere. Reset is synchronous and active high.

Top module: `pdac_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, and in the cycle after that edge, `addr_valid`, `addr_dual` and `proto_err` are 0.
- R2: A transaction starts only at an edge that samples `frame_n` low when the edge before sampled it high. While `frame_n` stays low, no further strobe or error is produced.
- R3: Single-address transaction (first-clock `cbe_n` not 4'b1101): `cmd` equals the first-clock `cbe_n`, `addr[31:0]` equals the first-clock `ad` and `addr[43:32]` is 0. `addr_dual` is 0.
- R4: A first-clock `cbe_n` of 4'b1101 marks a dual-address transaction, which is reported with `addr_dual` = 1. `addr_dual` is never 1 without `addr_valid`.
- R5: Dual-address transaction: `addr[31:0]` is the first-clock `ad` and `addr[43:32]` is the second-clock `ad[11:0]`.
- R6: Dual-address transaction: the second-clock `ad[31:12]` has no effect on any output.
- R7: Dual-address transaction: `cmd` equals the second-clock `cbe_n`.
- R8: If the second-clock `cbe_n` is again 4'b1101, `proto_err` pulses for one cycle and no `addr_valid` is produced for that transaction.
- R9: If `frame_n` is sampled high on the second clock of a dual-address transaction, `proto_err` pulses for one cycle and no `addr_valid` is produced for that transaction.
- R10: Let the edge that samples the first address clock be edge n. `addr_valid` is high for exactly one cycle: from edge n+1 in a single-address transaction, and from edge n+2 in a dual-address transaction. `addr_valid` and `proto_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Transaction frame, active low |
| ad | input | 32 | Multiplexed address/data lines |
| cbe_n | input | 4 | Command / byte-enable lines, active low |
| addr_valid | output | 1 | One-cycle strobe: address and command are valid |
| addr_dual | output | 1 | High with the strobe when the transaction had two address clocks |
| addr | output | 44 | Assembled address, held until the next strobe |
| cmd | output | 4 | Bus command, held until the next strobe |
| proto_err | output | 1 | One-cycle pulse on a malformed dual-address transaction |

## Verification
The assertions assume that `frame_n` follows the bus rule: once low it stays low for at least the address clock(s), and it must be high for at least one clock between transactions. Under that rule two strobes or two error pulses can never fall on adjacent cycles, and no start can occur while the second address clock is pending. The stimulus always puts an idle clock with `frame_n` high before each transaction and keeps `frame_n` low through the address clocks, except in the directed case that deliberately raises it early. Command values for single-address transactions are drawn at random but steered away from the reserved code.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_HIGH = 1'b1
  } phase_t;

endpackage

// File: rtl/pdac_sampler.sv
module pdac_sampler #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe_n,
  output logic             frame_q,
  output logic [AD_W-1:0]  ad_q,
  output logic [CBE_W-1:0] cbe_q,
  output logic             start
);

  logic frame_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q    <= 1'b1;
      frame_prev <= 1'b1;
      ad_q       <= '0;
      cbe_q      <= '1;
    end else begin
      frame_q    <= frame_n;
      frame_prev <= frame_q;
      ad_q       <= ad;
      cbe_q      <= cbe_n;
    end
  end

  // falling edge of the registered frame marks a new transaction
  assign start = frame_prev & ~frame_q;

endmodule

// File: rtl/pdac_fsm.sv
module pdac_fsm
  import pdac_pkg::*;
#(
  parameter int              AD_W      = 32,
  parameter int              ADDR_W    = 44,
  parameter int              CBE_W     = 4,
  parameter logic [CBE_W-1:0] DUAL_CODE = 4'b1101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              frame_q,
  input  logic [AD_W-1:0]   ad_q,
  input  logic [CBE_W-1:0]  cbe_q,
  output logic              load,
  output logic              dual_nx,
  output logic              err_nx,
  output logic [ADDR_W-1:0] addr_nx,
  output logic [CBE_W-1:0]  cmd_nx
);

  localparam int HI_W = ADDR_W - AD_W;

  phase_t          phase, phase_nx;
  logic [AD_W-1:0] lo_word;
  logic            is_code;
  logic            bad_high;

  assign is_code  = (cbe_q == DUAL_CODE);
  assign bad_high = frame_q | is_code;

  always_comb begin
    phase_nx = phase;
    load     = 1'b0;
    dual_nx  = 1'b0;
    err_nx   = 1'b0;
    addr_nx  = {{HI_W{1'b0}}, ad_q};
    cmd_nx   = cbe_q;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          if (is_code) phase_nx = PH_HIGH;
          else         load     = 1'b1;
        end
      end
      PH_HIGH: begin
        phase_nx = PH_IDLE;
        addr_nx  = {ad_q[HI_W-1:0], lo_word};
        if (bad_high) begin
          err_nx = 1'b1;
        end else begin
          load    = 1'b1;
          dual_nx = 1'b1;
        end
      end
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      lo_word <= '0;
    end else begin
      phase <= phase_nx;
      if (phase == PH_IDLE && start) lo_word <= ad_q;
    end
  end

  // R2: frame is still low in the second address clock, so no start can appear
  p_no_start_in_high_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HIGH) |-> !start);

  // R4: the upper-address phase lasts a single clock
  p_high_one_clock_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HIGH) |=> (phase == PH_IDLE));

endmodule

// File: rtl/pdac_outreg.sv
module pdac_outreg #(
  parameter int AD_W   = 32,
  parameter int ADDR_W = 44,
  parameter int CBE_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              dual_nx,
  input  logic              err_nx,
  input  logic [ADDR_W-1:0] addr_nx,
  input  logic [CBE_W-1:0]  cmd_nx,
  output logic              addr_valid,
  output logic              addr_dual,
  output logic              proto_err,
  output logic [ADDR_W-1:0] addr,
  output logic [CBE_W-1:0]  cmd
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      addr_dual  <= 1'b0;
      proto_err  <= 1'b0;
      addr       <= '0;
      cmd        <= '0;
    end else begin
      addr_valid <= load;
      addr_dual  <= load & dual_nx;
      proto_err  <= err_nx;
      if (load) begin
        addr <= addr_nx;
        cmd  <= cmd_nx;
      end
    end
  end

  // R10: strobe and error never coincide
  p_valid_err_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(addr_valid && proto_err));

  // R10: valid is a single-cycle pulse
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> !addr_valid);

  // R8: error is a single-cycle pulse
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> !proto_err);

  // R4: dual flag only accompanies a strobe
  p_dual_needs_valid_r4: assert property (@(posedge clk) disable iff (rst)
    addr_dual |-> addr_valid);

  // R3: one address clock never carries upper address bits
  p_single_hi_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !addr_dual) |-> (addr[ADDR_W-1:AD_W] == '0));

endmodule

// File: rtl/pdac_decoder.sv
module pdac_decoder #(
  parameter int               AD_W      = 32,
  parameter int               ADDR_W    = 44,
  parameter int               CBE_W     = 4,
  parameter logic [CBE_W-1:0] DUAL_CODE = 4'b1101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic [AD_W-1:0]   ad,
  input  logic [CBE_W-1:0]  cbe_n,
  output logic              addr_valid,
  output logic              addr_dual,
  output logic [ADDR_W-1:0] addr,
  output logic [CBE_W-1:0]  cmd,
  output logic              proto_err
);

  logic              frame_q, start;
  logic [AD_W-1:0]   ad_q;
  logic [CBE_W-1:0]  cbe_q;
  logic              load, dual_nx, err_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic [CBE_W-1:0]  cmd_nx;

  pdac_sampler #(.AD_W(AD_W), .CBE_W(CBE_W)) u_sampler (
    .clk(clk), .rst(rst), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
    .frame_q(frame_q), .ad_q(ad_q), .cbe_q(cbe_q), .start(start)
  );

  pdac_fsm #(.AD_W(AD_W), .ADDR_W(ADDR_W), .CBE_W(CBE_W), .DUAL_CODE(DUAL_CODE)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .frame_q(frame_q), .ad_q(ad_q),
    .cbe_q(cbe_q), .load(load), .dual_nx(dual_nx), .err_nx(err_nx),
    .addr_nx(addr_nx), .cmd_nx(cmd_nx)
  );

  pdac_outreg #(.AD_W(AD_W), .ADDR_W(ADDR_W), .CBE_W(CBE_W)) u_outreg (
    .clk(clk), .rst(rst), .load(load), .dual_nx(dual_nx), .err_nx(err_nx),
    .addr_nx(addr_nx), .cmd_nx(cmd_nx), .addr_valid(addr_valid),
    .addr_dual(addr_dual), .proto_err(proto_err), .addr(addr), .cmd(cmd)
  );

endmodule

// File: tb/pdac_decoder_bench.sv
module pdac_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] CODE = 4'b1101;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        addr_valid, addr_dual, proto_err;
  logic [43:0] addr;
  logic [3:0]  cmd;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  int          n_valid, n_err, v_cyc;
  logic [43:0] v_addr;
  logic [3:0]  v_cmd;
  logic        v_dual;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pdac_decoder u_pdac_decoder (
    .clk(clk), .rst(rst), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
    .addr_valid(addr_valid), .addr_dual(addr_dual), .addr(addr),
    .cmd(cmd), .proto_err(proto_err)
  );

  always @(negedge clk) begin
    if (addr_valid) begin
      n_valid = n_valid + 1;
      v_cyc   = cyc;
      v_addr  = addr;
      v_cmd   = cmd;
      v_dual  = addr_dual;
    end
    if (proto_err) n_err = n_err + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [43:0] exp_single(input logic [31:0] a);
    return {12'h000, a};
  endfunction

  function automatic logic [43:0] exp_dual(input logic [31:0] lo, input logic [31:0] hi);
    return {hi[11:0], lo};
  endfunction

  task automatic drive(input logic f, input logic [31:0] a, input logic [3:0] c);
    @(negedge clk);
    frame_n = f; ad = a; cbe_n = c;
  endtask

  task automatic clear_mon();
    n_valid = 0; n_err = 0; v_cyc = 0; v_addr = '0; v_cmd = '0; v_dual = 0;
  endtask

  task automatic finish_txn();
    drive(1'b1, 32'h0, 4'hF);
    repeat (4) drive(1'b1, 32'h0, 4'hF);
  endtask

  task automatic run_single(input logic [31:0] a, input logic [3:0] c);
    int k;
    clear_mon();
    drive(1'b1, 32'h0, 4'hF);
    drive(1'b0, a, c);
    k = cyc;
    repeat (3) drive(1'b0, $urandom, $urandom);
    finish_txn();
    chk(n_valid == 1, "R10", "single strobe count", n_valid, 1);
    chk(n_err == 0, "R10", "single err count", n_err, 0);
    chk(v_cyc - k == 2, "R10", "single latency", v_cyc - k, 2);
    chk(v_addr == exp_single(a), "R3", "single addr", v_addr, exp_single(a));
    chk(v_cmd == c, "R3", "single cmd", v_cmd, c);
    chk(v_dual == 1'b0, "R3", "single dual flag", v_dual, 0);
    chk(n_valid <= 1, "R2", "no restrobe while frame low", n_valid, 1);
  endtask

  task automatic run_dual(input logic [31:0] lo, input logic [31:0] hi, input logic [3:0] c);
    int k;
    clear_mon();
    drive(1'b1, 32'h0, 4'hF);
    drive(1'b0, lo, CODE);
    k = cyc;
    drive(1'b0, hi, c);
    repeat (2) drive(1'b0, $urandom, $urandom);
    finish_txn();
    chk(n_valid == 1, "R10", "dual strobe count", n_valid, 1);
    chk(n_err == 0, "R10", "dual err count", n_err, 0);
    chk(v_cyc - k == 3, "R10", "dual latency", v_cyc - k, 3);
    chk(v_dual == 1'b1, "R4", "dual flag", v_dual, 1);
    chk(v_addr == exp_dual(lo, hi), "R5", "dual addr", v_addr, exp_dual(lo, hi));
    chk(v_cmd == c, "R7", "dual cmd", v_cmd, c);
  endtask

  function automatic logic [3:0] safe_cmd(input logic [3:0] c);
    return (c == CODE) ? 4'h7 : c;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] lo, hi;
    logic [43:0] ea, eb;
    clear_mon();
    repeat (3) @(negedge clk);
    // R1: outputs clear during reset
    chk(!addr_valid && !addr_dual && !proto_err, "R1", "outputs in reset",
        {addr_valid, addr_dual, proto_err}, 0);
    @(negedge clk); rst = 1'b0;
    chk(!addr_valid && !addr_dual && !proto_err, "R1", "outputs after reset",
        {addr_valid, addr_dual, proto_err}, 0);

    // directed single and dual corners
    run_single(32'hFFFF_FFFF, 4'h6);
    run_single(32'h0000_0000, 4'h0);
    run_dual(32'h1234_5678, 32'h0000_0ABC, 4'h7);
    run_dual(32'hFFFF_FFFF, 32'h0000_0FFF, 4'hF);

    // R6: junk in upper lines of second clock is ignored
    lo = 32'hCAFE_0001;
    run_dual(lo, 32'hFFFF_F123, 4'h6);
    chk(v_addr == {12'h123, lo}, "R6", "upper junk ignored", v_addr, {12'h123, lo});
    ea = v_addr;
    run_dual(lo, 32'h5A5A_5123, 4'h6);
    eb = v_addr;
    chk(ea == eb, "R6", "same addr with other junk", eb, ea);

    // R8: reserved code repeated on second clock
    clear_mon();
    drive(1'b1, 0, 4'hF);
    drive(1'b0, 32'h1111_2222, CODE);
    drive(1'b0, 32'h0000_0333, CODE);
    drive(1'b0, 0, 4'h0);
    finish_txn();
    chk(n_err == 1, "R8", "err pulses on repeated code", n_err, 1);
    chk(n_valid == 0, "R8", "no strobe on repeated code", n_valid, 0);

    // R9: frame raised before second address clock
    clear_mon();
    drive(1'b1, 0, 4'hF);
    drive(1'b0, 32'h3333_4444, CODE);
    drive(1'b1, 32'h0000_0555, 4'h7);
    finish_txn();
    chk(n_err == 1, "R9", "err pulses on early frame", n_err, 1);
    chk(n_valid == 0, "R9", "no strobe on early frame", n_valid, 0);

    // R2: frame held low for a long stretch gives one strobe
    clear_mon();
    drive(1'b1, 0, 4'hF);
    drive(1'b0, 32'h0BAD_F00D, 4'h6);
    repeat (20) drive(1'b0, $urandom, $urandom);
    finish_txn();
    chk(n_valid == 1, "R2", "one strobe for long frame", n_valid, 1);
    chk(n_err == 0, "R2", "no err for long frame", n_err, 0);

    // R1: reset in the middle of a dual transaction drops it
    clear_mon();
    drive(1'b1, 0, 4'hF);
    drive(1'b0, 32'h7777_8888, CODE);
    @(negedge clk); rst = 1'b1; ad = 32'h0000_0999; cbe_n = 4'h7;
    drive(1'b1, 0, 4'hF);
    @(negedge clk); rst = 1'b0;
    finish_txn();
    chk(n_valid == 0 && n_err == 0, "R1", "reset drops pending transaction",
        {n_valid[7:0], n_err[7:0]}, 0);

    // random mix with fixed seed
    void'($urandom(32'd20240611));
    for (int i = 0; i < 40; i++) begin
      lo = $urandom;
      hi = $urandom;
      if ($urandom_range(0, 1) == 0) run_single(lo, safe_cmd(4'($urandom)));
      else                          run_dual(lo, hi, safe_cmd(4'($urandom)));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule